// File: doc/BRIEF.md
# Dataless Way Count Selector

This block decides, once per fixed evaluation epoch, how many cache ways beyond the permanently dataless ones should have their data arrays switched off. For every candidate count it is given an estimate of the extra misses that count would cause. It predicts a slowdown and an energy gain for each candidate. It then picks the candidate that gains the most energy while the predicted slowdown stays under a percentage limit written by software.

Prediction works as follows. The slowdown of a candidate is its extra misses times the configured miss latency, divided by a memory-level-parallelism estimate. That estimate is the number of cores that missed during the epoch. The gain of a candidate is the candidate count times a configured per-way static saving, minus its extra misses times a configured off-chip access energy. The percentage limit is turned into a cycle budget once per evaluation. The candidate test therefore needs no divider: the weighted miss cost is compared against the budget scaled by the parallelism estimate. Candidates are walked one per cycle.

The result goes to the cache controller as a count, a contiguous way mask and a one-cycle raise or lower command. Dynamically disabled ways sit directly below the static dataless ways at the top of the way index range.

Top module: `dlw_count_sel`

## Requirements
- R1: After reset the dynamic count is 0, the mask holds only the static dataless ways (bits NUM_WAYS-1 down to NUM_WAYS-STATIC_WAYS), and done, raise and lower are low.
- R2: An evaluation completes once per epoch: done_o is a one-cycle pulse, and consecutive pulses are exactly EPOCH_CYCLES cycles apart.
- R3: A candidate k (1..NUM_WAYS-STATIC_WAYS) fits only if extra_k * miss_lat < (limit * EPOCH_CYCLES / 100) * mlp holds, with integer division. Equality does not fit.
- R4: mlp is the number of cores whose miss count in core_miss_i is nonzero, with a floor of 1.
- R5: The gain of candidate k is k*way_save - access_energy*extra_k. Among fitting candidates the largest gain wins, and a tie goes to the smaller k.
- R6: The count falls back to 0 when no candidate fits or no fitting candidate has a gain above 0.
- R7: With each done pulse, step_up_o is high if the new count exceeds the previous one and step_down_o is high if it is below it. Neither is high when the count is unchanged or outside a done pulse.
- R8: Mask bit i is set exactly when i >= NUM_WAYS - STATIC_WAYS - dyn_ways, so all dataless ways are contiguous from the top.
- R9: The dynamic count never exceeds NUM_WAYS - STATIC_WAYS.
- R10: The limit changes only on a cycle with limit_we_i high, and a new value applies from the next evaluation. Data presented with limit_we_i low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| limit_we_i | input | 1 | Write strobe for the degradation limit |
| limit_wdata_i | input | LIM_W | Limit in integer percent |
| extra_miss_i | input | (NUM_WAYS-STATIC_WAYS)*MISS_W | Extra-miss estimate per candidate count, entry k at index k |
| core_miss_i | input | NUM_CORES*MISS_W | Per-core miss counts for the epoch |
| miss_lat_i | input | LAT_W | Configured miss latency in cycles |
| way_save_i | input | EN_W | Static energy saved per disabled data way |
| access_energy_i | input | EN_W | Energy per off-chip access |
| dyn_ways_o | output | CNT_W | Current dynamic dataless way count |
| off_mask_o | output | NUM_WAYS | Ways whose data array is absent or off |
| step_up_o | output | 1 | Count raised at this evaluation |
| step_down_o | output | 1 | Count lowered at this evaluation |
| done_o | output | 1 | Evaluation finished pulse |

## Verification
The hardest case to reach is the exact boundary of the fit test, where weighted miss cost equals the scaled budget and must be rejected. Reaching it also shows that the parallelism estimate really scales the budget. The bench picks a linear miss profile and a limit that make the budget an integer multiple of the per-step cost. It then moves only the set of active cores across three evaluations: none, two and four. The chosen count therefore steps between 0, 1 and 2. Tie-breaking and the interior gain peak are reached with a quadratic miss profile and with profiles in which two candidates give the same gain.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_SCAN,
    ST_DONE
  } sel_state_e;
endpackage

// File: rtl/dlw_epoch_timer.sv
module dlw_epoch_timer #(
  parameter int EPOCH_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int EP_W = $clog2(EPOCH_CYCLES);

  logic [EP_W-1:0] cnt_q;

  assign tick_o = (cnt_q == EP_W'(EPOCH_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + EP_W'(1);
  end
endmodule

// File: rtl/dlw_mlp_est.sv
module dlw_mlp_est #(
  parameter int NUM_CORES = 4,
  parameter int MISS_W    = 16,
  localparam int CORE_W   = $clog2(NUM_CORES + 1)
) (
  input  logic [NUM_CORES-1:0][MISS_W-1:0] core_miss_i,
  output logic [CORE_W-1:0]                mlp_o
);
  logic [CORE_W-1:0] active;

  always_comb begin
    active = '0;
    for (int c = 0; c < NUM_CORES; c++)
      active = active + CORE_W'(core_miss_i[c] != '0);
  end

  // floor of one keeps the budget nonzero when no core missed
  assign mlp_o = (active == '0) ? CORE_W'(1) : active;
endmodule

// File: rtl/dlw_cand_eval.sv
module dlw_cand_eval #(
  parameter int MISS_W  = 16,
  parameter int LAT_W   = 10,
  parameter int EN_W    = 16,
  parameter int CNT_W   = 4,
  parameter int BUD_W   = 32,
  parameter int CORE_W  = 3,
  localparam int CMP_W  = ((MISS_W + LAT_W) > (BUD_W + CORE_W) ? (MISS_W + LAT_W) : (BUD_W + CORE_W)) + 1,
  localparam int SAVE_W = EN_W + MISS_W + 2
) (
  input  logic [CNT_W-1:0]         k_i,
  input  logic [MISS_W-1:0]        extra_i,
  input  logic [LAT_W-1:0]         lat_i,
  input  logic [EN_W-1:0]          way_save_i,
  input  logic [EN_W-1:0]          access_energy_i,
  input  logic [BUD_W-1:0]         budget_i,
  input  logic [CORE_W-1:0]        mlp_i,
  output logic                     fits_o,
  output logic signed [SAVE_W-1:0] save_o
);
  logic [CMP_W-1:0]  cost_w, room_w;
  logic [SAVE_W-1:0] gain_w, loss_w;

  // cost/mlp < budget  <=>  cost < budget*mlp
  assign cost_w = CMP_W'(extra_i) * CMP_W'(lat_i);
  assign room_w = CMP_W'(budget_i) * CMP_W'(mlp_i);
  assign fits_o = cost_w < room_w;

  assign gain_w = SAVE_W'(k_i) * SAVE_W'(way_save_i);
  assign loss_w = SAVE_W'(access_energy_i) * SAVE_W'(extra_i);
  assign save_o = $signed(gain_w - loss_w);
endmodule

// File: rtl/dlw_way_mask.sv
module dlw_way_mask #(
  parameter int NUM_WAYS    = 16,
  parameter int STATIC_WAYS = 2,
  parameter int CNT_W       = 4
) (
  input  logic [CNT_W-1:0]    dyn_i,
  output logic [NUM_WAYS-1:0] mask_o
);
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_bit
    if (g >= NUM_WAYS - STATIC_WAYS) begin : g_static
      assign mask_o[g] = 1'b1;
    end else begin : g_dyn
      assign mask_o[g] = (32'(g) + 32'(dyn_i)) >= 32'(NUM_WAYS - STATIC_WAYS);
    end
  end
endmodule

// File: rtl/dlw_count_sel.sv
module dlw_count_sel
  import dlw_pkg::*;
#(
  parameter int NUM_WAYS     = 16,
  parameter int STATIC_WAYS  = 2,
  parameter int NUM_CORES    = 4,
  parameter int MISS_W       = 16,
  parameter int LAT_W        = 10,
  parameter int EN_W         = 16,
  parameter int LIM_W        = 7,
  parameter int EPOCH_CYCLES = 50_000_000,
  localparam int MAX_DYN     = NUM_WAYS - STATIC_WAYS,
  localparam int CNT_W       = $clog2(MAX_DYN + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             limit_we_i,
  input  logic [LIM_W-1:0]                 limit_wdata_i,
  input  logic [MAX_DYN:1][MISS_W-1:0]     extra_miss_i,
  input  logic [NUM_CORES-1:0][MISS_W-1:0] core_miss_i,
  input  logic [LAT_W-1:0]                 miss_lat_i,
  input  logic [EN_W-1:0]                  way_save_i,
  input  logic [EN_W-1:0]                  access_energy_i,
  output logic [CNT_W-1:0]                 dyn_ways_o,
  output logic [NUM_WAYS-1:0]              off_mask_o,
  output logic                             step_up_o,
  output logic                             step_down_o,
  output logic                             done_o
);
  localparam int EP_W   = $clog2(EPOCH_CYCLES + 1);
  localparam int BUD_W  = LIM_W + EP_W;
  localparam int CORE_W = $clog2(NUM_CORES + 1);
  localparam int SAVE_W = EN_W + MISS_W + 2;

  sel_state_e                       state_q;
  logic [LIM_W-1:0]                 limit_q;
  logic [MAX_DYN:1][MISS_W-1:0]     extra_q;
  logic [NUM_CORES-1:0][MISS_W-1:0] core_q;
  logic [BUD_W-1:0]                 budget_q, bud_prod, bud_div;
  logic [CORE_W-1:0]                mlp_q, mlp_w;
  logic [CNT_W-1:0]                 k_q, best_k_q, dyn_q;
  logic signed [SAVE_W-1:0]         best_save_q, save_w;
  logic                             fits_w, tick_w;
  logic                             done_q, up_q, down_q;

  dlw_epoch_timer #(.EPOCH_CYCLES(EPOCH_CYCLES)) timer_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_w)
  );

  dlw_mlp_est #(.NUM_CORES(NUM_CORES), .MISS_W(MISS_W)) mlp_i (
    .core_miss_i(core_q),
    .mlp_o      (mlp_w)
  );

  dlw_cand_eval #(
    .MISS_W(MISS_W), .LAT_W(LAT_W), .EN_W(EN_W), .CNT_W(CNT_W),
    .BUD_W(BUD_W), .CORE_W(CORE_W)
  ) eval_i (
    .k_i            (k_q),
    .extra_i        (extra_q[k_q]),
    .lat_i          (miss_lat_i),
    .way_save_i     (way_save_i),
    .access_energy_i(access_energy_i),
    .budget_i       (budget_q),
    .mlp_i          (mlp_q),
    .fits_o         (fits_w),
    .save_o         (save_w)
  );

  dlw_way_mask #(.NUM_WAYS(NUM_WAYS), .STATIC_WAYS(STATIC_WAYS), .CNT_W(CNT_W)) mask_i (
    .dyn_i (dyn_q),
    .mask_o(off_mask_o)
  );

  // percent limit to epoch-cycle budget, once per evaluation
  assign bud_prod = BUD_W'(limit_q) * BUD_W'(EPOCH_CYCLES);
  assign bud_div  = bud_prod / BUD_W'(100);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      limit_q     <= '0;
      extra_q     <= '0;
      core_q      <= '0;
      budget_q    <= '0;
      mlp_q       <= CORE_W'(1);
      k_q         <= CNT_W'(1);
      best_k_q    <= '0;
      best_save_q <= '0;
      dyn_q       <= '0;
      done_q      <= 1'b0;
      up_q        <= 1'b0;
      down_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      up_q   <= 1'b0;
      down_q <= 1'b0;
      if (limit_we_i) limit_q <= limit_wdata_i;
      unique case (state_q)
        ST_IDLE: if (tick_w) begin
          extra_q <= extra_miss_i;
          core_q  <= core_miss_i;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          budget_q    <= bud_div;
          mlp_q       <= mlp_w;
          k_q         <= CNT_W'(1);
          best_k_q    <= '0;   // zero ways: fallback, gain 0
          best_save_q <= '0;
          state_q     <= ST_SCAN;
        end
        ST_SCAN: begin
          if (fits_w && (save_w > best_save_q)) begin
            best_k_q    <= k_q;
            best_save_q <= save_w;
          end
          if (k_q == CNT_W'(MAX_DYN)) state_q <= ST_DONE;
          else                        k_q     <= k_q + CNT_W'(1);
        end
        ST_DONE: begin
          dyn_q   <= best_k_q;
          done_q  <= 1'b1;
          up_q    <= best_k_q > dyn_q;
          down_q  <= best_k_q < dyn_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dyn_ways_o  = dyn_q;
  assign step_up_o   = up_q;
  assign step_down_o = down_q;
  assign done_o      = done_q;
endmodule

// File: rtl/dlw_count_sel_chk.sv
module dlw_count_sel_chk #(
  parameter int NUM_WAYS    = 16,
  parameter int STATIC_WAYS = 2,
  parameter int CNT_W       = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [CNT_W-1:0]    dyn_ways_o,
  input logic [NUM_WAYS-1:0] off_mask_o,
  input logic                step_up_o,
  input logic                step_down_o,
  input logic                done_o
);
  localparam int MAX_DYN = NUM_WAYS - STATIC_WAYS;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_between_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(dyn_ways_o));

  p_step_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_up_o && step_down_o));

  p_step_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_up_o || step_down_o) |-> done_o);

  p_up_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && step_up_o) |-> (dyn_ways_o > $past(dyn_ways_o)));

  p_down_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && step_down_o) |-> (dyn_ways_o < $past(dyn_ways_o)));

  p_mask_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(off_mask_o) == STATIC_WAYS + 32'(dyn_ways_o)) && off_mask_o[NUM_WAYS-1]);

  p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(dyn_ways_o) <= MAX_DYN);
endmodule

bind dlw_count_sel dlw_count_sel_chk #(
  .NUM_WAYS(NUM_WAYS), .STATIC_WAYS(STATIC_WAYS), .CNT_W(CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dyn_ways_o (dyn_ways_o),
  .off_mask_o (off_mask_o),
  .step_up_o  (step_up_o),
  .step_down_o(step_down_o),
  .done_o     (done_o)
);

// File: tb/dlw_count_sel_tb.sv
module dlw_count_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int SW = 2;
  localparam int MD = NW - SW;
  localparam int NC = 4;
  localparam int EPOCH = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic limit_we = 1'b0;
  logic [6:0] limit_wdata = '0;
  logic [MD:1][15:0] extra = '0;
  logic [NC-1:0][15:0] cores = '0;
  logic [9:0] lat = '0;
  logic [15:0] wsave = '0;
  logic [15:0] aen = '0;
  logic [3:0] dyn;
  logic [NW-1:0] mask;
  logic up, down, done;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlw_count_sel #(
    .NUM_WAYS(NW), .STATIC_WAYS(SW), .NUM_CORES(NC), .EPOCH_CYCLES(EPOCH)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .limit_we_i(limit_we), .limit_wdata_i(limit_wdata),
    .extra_miss_i(extra), .core_miss_i(cores),
    .miss_lat_i(lat), .way_save_i(wsave), .access_energy_i(aen),
    .dyn_ways_o(dyn), .off_mask_o(mask),
    .step_up_o(up), .step_down_o(down), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_mask(input int d);
    return 16'(32'hFFFF << (MD - d));
  endfunction

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic write_limit(input logic [6:0] v);
    limit_wdata = v;
    limit_we = 1'b1;
    @(negedge clk);
    limit_we = 1'b0;
  endtask

  // sync on an evaluation, apply inputs, wait for the next one, check
  task automatic run_epoch(input string req, input int exp_d, input logic exp_up, input logic exp_dn);
    wait_done();
    check(req, 32'(dyn), 32'(exp_d));
    check(req, 32'(mask), 32'(exp_mask(exp_d)));
    check(req, 32'(up), 32'(exp_up));
    check(req, 32'(down), 32'(exp_dn));
  endtask

  task automatic t_reset();
    // R1
    check("R1 count", 32'(dyn), 0);
    check("R1 mask", 32'(mask), 32'h0000_C000);
    check("R1 strobes", 32'({done, up, down}), 0);
  endtask

  task automatic t_period();
    int n = 0;
    wait_done();
    @(negedge clk);
    n = 1;
    check("R2 pulse width", 32'(done), 0);
    while (!done) begin @(negedge clk); n++; end
    check("R2 period", 32'(n), 32'(EPOCH));
  endtask

  task automatic t_all_free();
    // R5 R9: zero misses, gain grows with k, full range chosen
    wait_done();
    write_limit(7'd100);
    lat = 10; wsave = 50; aen = 3;
    extra = '0;
    cores = {16'd1, 16'd1, 16'd1, 16'd1};
    run_epoch("R5 R7 R8 R9 all ways", MD, 1'b1, 1'b0);
  endtask

  task automatic t_peak();
    // R5: gain 100k-10k^2 peaks at k=5
    wait_done();
    lat = 1; wsave = 100; aen = 10;
    for (int k = 1; k <= MD; k++) extra[k] = 16'(k * k);
    run_epoch("R5 interior peak", 5, 1'b0, 1'b1);
  endtask

  task automatic t_tie();
    // R5: k=2 and k=3 both gain 10, smaller wins
    wait_done();
    lat = 1; wsave = 10; aen = 10;
    for (int k = 1; k <= MD; k++) extra[k] = 16'd50;
    extra[1] = 16'd1; extra[2] = 16'd1; extra[3] = 16'd2;
    run_epoch("R5 tie", 2, 1'b0, 1'b1);
  endtask

  task automatic t_hold();
    // R7 unchanged count; R10 data without strobe ignored
    wait_done();
    limit_wdata = 7'd0;
    run_epoch("R7 R10 hold", 2, 1'b0, 1'b0);
  endtask

  task automatic t_strict();
    // R3: budget 50*2=100 equals cost of k=1 -> rejected
    wait_done();
    write_limit(7'd50);
    lat = 10; wsave = 1; aen = 0;
    for (int k = 1; k <= MD; k++) extra[k] = 16'(k * 10);
    cores = {16'd0, 16'd0, 16'd7, 16'd3};
    run_epoch("R3 R6 equality rejected", 0, 1'b0, 1'b1);
  endtask

  task automatic t_mlp();
    // R4: limit 75, cost 100k; budget 75*mlp
    wait_done();
    write_limit(7'd75);
    run_epoch("R4 R10 two cores", 1, 1'b1, 1'b0);
    cores = {16'd1, 16'd2, 16'd3, 16'd4};
    run_epoch("R4 four cores", 2, 1'b1, 1'b0);
    cores = '0;
    run_epoch("R4 floor of one", 0, 1'b0, 1'b1);
  endtask

  task automatic t_fallback();
    // R6: no positive gain anywhere
    wait_done();
    write_limit(7'd100);
    lat = 1; wsave = 1; aen = 100;
    for (int k = 1; k <= MD; k++) extra[k] = 16'd1;
    cores = {16'd1, 16'd1, 16'd1, 16'd1};
    run_epoch("R6 negative gain", 0, 1'b0, 1'b0);
    // R6 R10: zero limit blocks an otherwise free choice
    wsave = 50; aen = 0; extra = '0;
    run_epoch("R6 free choice baseline", MD, 1'b1, 1'b0);
    write_limit(7'd0);
    run_epoch("R6 R10 zero limit", 0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_period();
    t_all_free();
    t_peak();
    t_tie();
    t_hold();
    t_strict();
    t_mlp();
    t_fallback();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R2 watchdog: actual no completion expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule